// File: doc/BRIEF.md
# Serial command register access controller

This block is the configuration port of a four-channel device. A host drives a chip select (active low), a serial clock and a serial data line, and reads back on a serial output. Every transaction starts with a command byte. The command byte names the direction, the target space and an address. The target space is one of three: eight global registers, pairs of per-channel local registers, or a coefficient memory of 16-bit words. The coefficient memory is moved in bursts of one eight-word block. All serial lines are oversampled by the system clock. Data is taken on the rising serial clock edge and launched on the falling edge.

A channel-enable field in one global register decides which channels the per-channel storage touches. Several channels may be written in one pass. One chip-select frame may hold any number of complete transactions back to back. Raising chip select aborts whatever is in flight and returns the decoder to waiting for a command.

The controller has three states: `ST_CMD` (collect a command byte), `ST_WR` (take data bytes) and `ST_RD` (send the identification byte, then the data). The transitions are:
- `ST_CMD`→`ST_WR` on a completed command byte with bit 7 set.
- `ST_CMD`→`ST_RD` on a completed command byte with bit 7 clear.
- `ST_WR`→`ST_CMD` after the last data byte of the transaction.
- `ST_RD`→`ST_CMD` after the last data byte has been sent.
- Any state→`ST_CMD` when chip select is high.

Top module: `sercmd_port`

## Requirements
- R1: The command byte is sent MSB first. Bit 7 is 1 for write and 0 for read. Bits 6:5 pick the space: 00 local, 01 global, 11 coefficient, 10 undefined. Bits 4:0 are the address. Several complete transactions may follow each other inside one chip-select frame.
- R2: A global access at address a (0..7) moves one data byte to or from global register a+1.
- R3: Bits 7:4 of global register 6 (address 5) enable channels 4..1, with bit 4 for channel 1. Local and per-channel coefficient writes go to every enabled channel. Reads of them return the lowest-numbered enabled channel. With no channel enabled, such writes are ignored and such reads return 0.
- R4: A local access at address a (1..4) moves two bytes: local register 2a first, then register 2a-1.
- R5: Every read sends 1000_0001 first, then the data bytes, each MSB first. Serial out changes only after a falling serial clock edge. Serial out is 0 outside reads and while chip select is high.
- R6: A coefficient command moves the whole block that contains its address, 16 bytes in all. Words are taken from the block's top address down to its bottom, high byte first. Address bits 2:0 of the command do not change the order.
- R7: On coefficient writes, bits 1:0 of each word are ignored. On reads, those bits return 0.
- R8: The block of coefficient words 16..23 is kept separately per channel. The other blocks are shared by all channels.
- R9: Raising chip select abandons the current byte and every remaining one. Completed coefficient words stay written. A word whose low byte has not arrived is not written. The next frame starts with a command byte.
- R10: Undefined targets are ignored on write and return zero data on read. These are global addresses 8..31, local addresses 0 and 5..31, and space 10. Undefined global and space-10 accesses are one byte long; undefined local accesses are two bytes long.
- R11: After reset all registers and coefficient words read 0, and serial out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |

## Verification
The bench builds the block with its defaults:
- four channels
- eight global registers
- four local register pairs
- four coefficient blocks of eight words, with block 2 as the per-channel one

With these values the 5-bit address exactly spans the coefficient memory. Every undefined global and local address is reachable, and one block tests the per-channel path against three shared ones. The channel-enable field can take every pattern from none to all four. This exercises broadcast writes, lowest-channel reads and the all-disabled case.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    typedef enum logic [1:0] {
        SP_LOC = 2'b00,
        SP_GLB = 2'b01,
        SP_RSV = 2'b10,
        SP_COE = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        ST_CMD = 2'b00,
        ST_WR  = 2'b01,
        ST_RD  = 2'b10
    } state_e;

    localparam logic [7:0] ID_BYTE = 8'h81;

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sel,
    output logic rise,
    output logic fall,
    output logic din
);
    logic [2:0] sck_q;
    logic [1:0] cs_q;
    logic [1:0] di_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            cs_q  <= 2'b11;
            di_q  <= '0;
        end else begin
            sck_q <= {sck_q[1:0], sclk};
            cs_q  <= {cs_q[0], cs_n};
            di_q  <= {di_q[0], sdi};
        end
    end

    assign sel  = ~cs_q[1];
    assign rise = sck_q[1] & ~sck_q[2];
    assign fall = ~sck_q[1] & sck_q[2];
    assign din  = di_q[1];
endmodule

// File: rtl/sercmd_fsm.sv
module sercmd_fsm
    import sercmd_pkg::*;
#(
    parameter int NGLB   = 8,
    parameter int NLPAIR = 4,
    parameter int NBLK   = 4,
    parameter int BWORDS = 8,
    localparam int GW  = $clog2(NGLB),
    localparam int LW  = $clog2(2 * NLPAIR),
    localparam int CAW = $clog2(NBLK * BWORDS),
    localparam int WW  = $clog2(BWORDS),
    localparam int BIW = $clog2(2 * BWORDS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           rise,
    input  logic           fall,
    input  logic           din,
    output logic           sdo,
    output logic           glb_we,
    output logic [GW-1:0]  glb_idx,
    output logic           loc_we,
    output logic [LW-1:0]  loc_idx,
    output logic           coe_we,
    output logic [CAW-1:0] coe_addr,
    output logic [7:0]     wbyte,
    output logic [15:0]    wword,
    input  logic [7:0]     glb_q,
    input  logic [7:0]     loc_q,
    input  logic [15:0]    coe_q
);
    state_e           state, nstate;
    space_e           space;
    logic [2:0]       cnt;
    logic [6:0]       sh;
    logic [7:0]       tx, hi, rxb, rd_byte;
    logic [4:0]       addr;
    logic [BIW-1:0]   bidx, blen;
    logic             byte_done, in_wr, glb_ok, loc_ok;

    assign rxb       = {sh, din};
    assign byte_done = sel & rise & (cnt == 3'd7);
    assign in_wr     = byte_done && (state == ST_WR);
    assign glb_ok    = addr < 5'(NGLB);
    assign loc_ok    = (addr != 5'd0) && (addr <= 5'(NLPAIR));

    always_comb begin
        unique case (space)
            SP_LOC:  blen = BIW'(2);
            SP_COE:  blen = BIW'(2 * BWORDS);
            default: blen = BIW'(1);
        endcase
    end

    assign glb_idx  = addr[GW-1:0];
    assign loc_idx  = LW'({addr, 1'b0} - 6'd1 - 6'(bidx));
    assign coe_addr = {addr[CAW-1:WW], WW'(BWORDS - 1) - bidx[WW:1]};
    assign wbyte    = rxb;
    assign wword    = {hi, rxb};
    assign glb_we   = in_wr && (space == SP_GLB) && glb_ok;
    assign loc_we   = in_wr && (space == SP_LOC) && loc_ok;
    assign coe_we   = in_wr && (space == SP_COE) && bidx[0];

    always_comb begin
        unique case (space)
            SP_GLB:  rd_byte = glb_ok ? glb_q : 8'h00;
            SP_LOC:  rd_byte = loc_ok ? loc_q : 8'h00;
            SP_COE:  rd_byte = bidx[0] ? coe_q[7:0] : coe_q[15:8];
            default: rd_byte = 8'h00;
        endcase
    end

    // next state
    always_comb begin
        nstate = state;
        if (!sel) begin
            nstate = ST_CMD;
        end else if (byte_done) begin
            unique case (state)
                ST_CMD:  nstate = rxb[7] ? ST_WR : ST_RD;
                ST_WR:   if (bidx == blen - BIW'(1)) nstate = ST_CMD;
                ST_RD:   if (bidx == blen) nstate = ST_CMD;
                default: nstate = ST_CMD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= nstate;
    end

    // shifting, command capture and serial output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sh    <= '0;
            tx    <= '0;
            hi    <= '0;
            addr  <= '0;
            space <= SP_GLB;
            bidx  <= '0;
            sdo   <= 1'b0;
        end else if (!sel) begin
            cnt  <= '0;
            bidx <= '0;
            sdo  <= 1'b0;
        end else begin
            if (rise) begin
                cnt <= cnt + 3'd1;
                sh  <= {sh[5:0], din};
            end
            if (fall) sdo <= (state == ST_RD) ? tx[3'd7 - cnt] : 1'b0;
            if (byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        space <= space_e'(rxb[6:5]);
                        addr  <= rxb[4:0];
                        bidx  <= '0;
                        tx    <= ID_BYTE;
                    end
                    ST_WR: begin
                        if (!bidx[0]) hi <= rxb;
                        bidx <= bidx + BIW'(1);
                    end
                    ST_RD: begin
                        tx   <= rd_byte;
                        bidx <= bidx + BIW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: deselect returns to command collection with a clean bit count
    a_r9_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (state == ST_CMD && cnt == 3'd0));

    // R5: output quiet when deselected
    a_r5_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdo);

    // R5: output moves only on a falling serial edge
    a_r5_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !fall) |=> $stable(sdo));

    // R1: one target space per strobe
    a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({glb_we, loc_we, coe_we}));

    // R6: a write never runs past its transaction length
    a_r6_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR) |-> (bidx < blen));
endmodule

// File: rtl/sercmd_store.sv
module sercmd_store #(
    parameter int NCH      = 4,
    parameter int NGLB     = 8,
    parameter int NLPAIR   = 4,
    parameter int NBLK     = 4,
    parameter int BWORDS   = 8,
    parameter int TONE_BLK = 2,
    parameter int CE_REG   = 5,
    parameter int CE_LSB   = 4,
    localparam int GW  = $clog2(NGLB),
    localparam int LW  = $clog2(2 * NLPAIR),
    localparam int CAW = $clog2(NBLK * BWORDS),
    localparam int WW  = $clog2(BWORDS),
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           glb_we,
    input  logic [GW-1:0]  glb_idx,
    input  logic           loc_we,
    input  logic [LW-1:0]  loc_idx,
    input  logic           coe_we,
    input  logic [CAW-1:0] coe_addr,
    input  logic [7:0]     wbyte,
    input  logic [15:0]    wword,
    output logic [7:0]     glb_q,
    output logic [7:0]     loc_q,
    output logic [15:0]    coe_q
);
    logic [7:0]            greg [NGLB];
    logic [15:0]           cshr [NBLK * BWORDS];
    logic [NCH-1:0]        ce;
    logic                  tone;
    logic [15:0]           wmask;
    logic [CHW-1:0]        first;
    logic [NCH-1:0][7:0]   loc_ch;
    logic [NCH-1:0][15:0]  coe_ch;

    assign ce    = greg[CE_REG][CE_LSB +: NCH];
    assign tone  = coe_addr[CAW-1:WW] == (CAW - WW)'(TONE_BLK);
    assign wmask = wword & 16'hFFFC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NGLB; i++) greg[i] <= '0;
        end else if (glb_we) begin
            greg[glb_idx] <= wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK * BWORDS; i++) cshr[i] <= '0;
        end else if (coe_we && !tone) begin
            cshr[coe_addr] <= wmask;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [7:0]  lmem [2 * NLPAIR];
        logic [15:0] tmem [BWORDS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < 2 * NLPAIR; i++) lmem[i] <= '0;
                for (int i = 0; i < BWORDS; i++)     tmem[i] <= '0;
            end else begin
                if (loc_we && ce[ch])         lmem[loc_idx] <= wbyte;
                if (coe_we && tone && ce[ch]) tmem[coe_addr[WW-1:0]] <= wmask;
            end
        end

        assign loc_ch[ch] = lmem[loc_idx];
        assign coe_ch[ch] = tmem[coe_addr[WW-1:0]];
    end

    always_comb begin
        first = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (ce[c]) first = CHW'(c);
        end
    end

    assign glb_q = greg[glb_idx];
    assign loc_q = (|ce) ? loc_ch[first] : 8'h00;
    assign coe_q = tone ? ((|ce) ? coe_ch[first] : 16'h0000) : cshr[coe_addr];

    // R7: stored coefficient words never carry the two low bits
    a_r7_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        coe_q[1:0] == 2'b00);

    // R3: with every channel disabled nothing per-channel is visible
    a_r3_no_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (ce == '0) |-> (loc_q == 8'h00));
endmodule

// File: rtl/sercmd_port.sv
module sercmd_port #(
    parameter int NCH      = 4,
    parameter int NGLB     = 8,
    parameter int NLPAIR   = 4,
    parameter int NBLK     = 4,
    parameter int BWORDS   = 8,
    parameter int TONE_BLK = 2,
    parameter int CE_REG   = 5,
    parameter int CE_LSB   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo
);
    localparam int GW  = $clog2(NGLB);
    localparam int LW  = $clog2(2 * NLPAIR);
    localparam int CAW = $clog2(NBLK * BWORDS);

    logic           sel, rise, fall, din;
    logic           glb_we, loc_we, coe_we;
    logic [GW-1:0]  glb_idx;
    logic [LW-1:0]  loc_idx;
    logic [CAW-1:0] coe_addr;
    logic [7:0]     wbyte, glb_q, loc_q;
    logic [15:0]    wword, coe_q;

    sercmd_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sel(sel), .rise(rise), .fall(fall), .din(din)
    );

    sercmd_fsm #(
        .NGLB(NGLB), .NLPAIR(NLPAIR), .NBLK(NBLK), .BWORDS(BWORDS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .fall(fall), .din(din),
        .sdo(sdo),
        .glb_we(glb_we), .glb_idx(glb_idx),
        .loc_we(loc_we), .loc_idx(loc_idx),
        .coe_we(coe_we), .coe_addr(coe_addr),
        .wbyte(wbyte), .wword(wword),
        .glb_q(glb_q), .loc_q(loc_q), .coe_q(coe_q)
    );

    sercmd_store #(
        .NCH(NCH), .NGLB(NGLB), .NLPAIR(NLPAIR), .NBLK(NBLK), .BWORDS(BWORDS),
        .TONE_BLK(TONE_BLK), .CE_REG(CE_REG), .CE_LSB(CE_LSB)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .glb_we(glb_we), .glb_idx(glb_idx),
        .loc_we(loc_we), .loc_idx(loc_idx),
        .coe_we(coe_we), .coe_addr(coe_addr),
        .wbyte(wbyte), .wword(wword),
        .glb_q(glb_q), .loc_q(loc_q), .coe_q(coe_q)
    );
endmodule

// File: tb/sim_sercmd_port.sv
`timescale 1ns/1ps
module sim_sercmd_port;
    localparam int HP = 6;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    logic [7:0]  m_glb [8];
    logic [7:0]  m_loc [4][8];
    logic [15:0] m_csh [32];
    logic [15:0] m_cch [4][8];
    logic [15:0] wbuf  [8];

    always #2.5 clk = ~clk;

    sercmd_port u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] b, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            tick(HP);
            r[i] = sdo;
            sclk = 1'b1;
            tick(HP);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        xbits(b, 8, r);
    endtask

    task automatic open_f();
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic close_f();
        tick(HP);
        cs_n = 1'b1;
        tick(2 * HP);
    endtask

    function automatic logic [3:0] ce_m();
        return m_glb[5][7:4];
    endfunction

    function automatic int first_ch();
        for (int c = 0; c < 4; c++) if (ce_m()[c]) return c;
        return -1;
    endfunction

    function automatic logic [15:0] exp_word(input logic [4:0] a, input int k);
        logic [4:0] wa;
        wa = {a[4:3], 3'b000} + 5'(7 - k);
        if (a[4:3] == 2'd2) return (first_ch() < 0) ? 16'h0 : m_cch[first_ch()][7 - k];
        return m_csh[wa];
    endfunction

    task automatic op_gwr(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] r;
        xfer({3'b101, a}, r);
        xfer(d, r);
        if (a < 5'd8) m_glb[a[2:0]] = d;
    endtask

    task automatic op_grd(input logic [4:0] a, input string tag);
        logic [7:0] id, r;
        xfer({3'b001, a}, id);
        xfer(8'h00, id);
        xfer(8'h00, r);
        check({tag, " id"}, {8'h0, id}, 16'h0081);
        check(tag, {8'h0, r}, (a < 5'd8) ? {8'h0, m_glb[a[2:0]]} : 16'h0);
    endtask

    task automatic op_lwr(input logic [4:0] a, input logic [7:0] h, input logic [7:0] l);
        logic [7:0] r;
        xfer({3'b100, a}, r);
        xfer(h, r);
        xfer(l, r);
        if (a >= 5'd1 && a <= 5'd4)
            for (int c = 0; c < 4; c++)
                if (ce_m()[c]) begin
                    m_loc[c][2 * a - 1] = h;
                    m_loc[c][2 * a - 2] = l;
                end
    endtask

    task automatic op_lrd(input logic [4:0] a, input string tag);
        logic [7:0] id, rh, rl, eh, el;
        int f;
        f = first_ch();
        eh = 8'h0; el = 8'h0;
        if (a >= 5'd1 && a <= 5'd4 && f >= 0) begin
            eh = m_loc[f][2 * a - 1];
            el = m_loc[f][2 * a - 2];
        end
        xfer({3'b000, a}, id);
        xfer(8'h00, id);
        xfer(8'h00, rh);
        xfer(8'h00, rl);
        check({tag, " id"}, {8'h0, id}, 16'h0081);
        check({tag, " high reg"}, {8'h0, rh}, {8'h0, eh});
        check({tag, " low reg"}, {8'h0, rl}, {8'h0, el});
    endtask

    task automatic op_cwr(input logic [4:0] a, input int nb);
        logic [7:0] r;
        logic [4:0] wa;
        xfer({3'b111, a}, r);
        for (int b = 0; b < nb; b++) begin
            int k;
            k = b / 2;
            if (b % 2 == 0) begin
                xfer(wbuf[k][15:8], r);
            end else begin
                xfer(wbuf[k][7:0], r);
                wa = {a[4:3], 3'b000} + 5'(7 - k);
                if (a[4:3] == 2'd2) begin
                    for (int c = 0; c < 4; c++)
                        if (ce_m()[c]) m_cch[c][7 - k] = wbuf[k] & 16'hFFFC;
                end else begin
                    m_csh[wa] = wbuf[k] & 16'hFFFC;
                end
            end
        end
    endtask

    task automatic op_crd(input logic [4:0] a, input string tag);
        logic [7:0] id, rh, rl;
        logic [15:0] e;
        xfer({3'b011, a}, id);
        xfer(8'h00, id);
        check({tag, " id"}, {8'h0, id}, 16'h0081);
        for (int k = 0; k < 8; k++) begin
            e = exp_word(a, k);
            xfer(8'h00, rh);
            xfer(8'h00, rl);
            check(tag, {rh, rl}, e);
        end
    endtask

    task automatic fill_wbuf();
        for (int k = 0; k < 8; k++) wbuf[k] = 16'($urandom());
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, all requirements unchecked");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, id;
        void'($urandom(32'd7351));
        for (int i = 0; i < 8; i++) m_glb[i] = '0;
        for (int c = 0; c < 4; c++) for (int i = 0; i < 8; i++) begin
            m_loc[c][i] = '0;
            m_cch[c][i] = '0;
        end
        for (int i = 0; i < 32; i++) m_csh[i] = '0;

        tick(10);
        check("R11 sdo in reset", {15'h0, sdo}, 16'h0);
        rst_n = 1'b1;
        tick(5);

        // R11: everything reads zero after reset
        open_f();
        op_grd(5'd0, "R11 global 1 after reset");
        op_grd(5'd5, "R11 global 6 after reset");
        op_crd(5'd8, "R11 coefficient block after reset");
        close_f();
        check("R5 sdo low after frame", {15'h0, sdo}, 16'h0);

        // R1 and R2: write then read within one frame
        open_f();
        op_gwr(5'd0, 8'h5A);
        op_grd(5'd0, "R1 R2 global 1 same frame");
        op_gwr(5'd7, 8'hC3);
        close_f();
        open_f(); op_grd(5'd7, "R2 global 8"); close_f();
        open_f(); op_grd(5'd0, "R2 global 1 kept"); close_f();

        // R3 and R4: channel 1 via 0001_0010
        open_f();
        op_gwr(5'd5, 8'h12);
        op_lwr(5'd1, 8'hA5, 8'h3C);
        op_lrd(5'd1, "R4 local pair 1 channel 1");
        op_lwr(5'd4, 8'h81, 8'h7E);
        op_lrd(5'd4, "R4 local pair 4 channel 1");
        close_f();
        open_f();
        op_gwr(5'd5, 8'h20);
        op_lrd(5'd1, "R3 channel 2 isolated");
        op_lwr(5'd1, 8'h11, 8'h22);
        op_gwr(5'd5, 8'h30);
        op_lrd(5'd1, "R3 lowest enabled channel");
        op_gwr(5'd5, 8'h00);
        op_lwr(5'd1, 8'hEE, 8'hDD);
        op_lrd(5'd1, "R3 no channel reads zero");
        op_gwr(5'd5, 8'h10);
        op_lrd(5'd1, "R3 disabled write ignored");
        op_gwr(5'd5, 8'hF0);
        op_lwr(5'd2, 8'h99, 8'h66);
        op_gwr(5'd5, 8'h80);
        op_lrd(5'd2, "R3 broadcast reached channel 4");
        close_f();

        // R6 and R7: burst order and ignored low bits, odd start address
        for (int k = 0; k < 8; k++) wbuf[k] = 16'h1003 + 16'(k * 16'h1111);
        open_f(); op_cwr(5'd5, 16); close_f();
        open_f(); op_crd(5'd0, "R6 R7 block 0 descending masked"); close_f();
        fill_wbuf();
        open_f(); op_cwr(5'd31, 16); op_crd(5'd24, "R6 block 3 same frame"); close_f();

        // R8: per-channel tone block against a shared block
        open_f();
        op_gwr(5'd5, 8'h10);
        fill_wbuf(); op_cwr(5'd16, 16);
        op_gwr(5'd5, 8'h20);
        op_crd(5'd16, "R8 tone block channel 2 untouched");
        fill_wbuf(); op_cwr(5'd20, 16);
        op_gwr(5'd5, 8'h10);
        op_crd(5'd16, "R8 tone block channel 1 kept");
        fill_wbuf(); op_cwr(5'd8, 16);
        op_gwr(5'd5, 8'h40);
        op_crd(5'd8, "R8 shared block seen by channel 3");
        op_gwr(5'd5, 8'h00);
        op_crd(5'd16, "R3 R8 tone block no channel");
        close_f();

        // R9: abort mid-burst after two words and a high byte
        fill_wbuf();
        open_f(); op_cwr(5'd24, 5); close_f();
        open_f(); op_crd(5'd24, "R9 partial burst"); close_f();
        open_f();
        xfer({3'b101, 5'd1}, r);
        xbits(8'hFF, 4, r);
        close_f();
        open_f(); op_grd(5'd1, "R9 aborted global byte"); close_f();

        // R10: undefined targets
        open_f();
        op_gwr(5'd9, 8'hFF);
        op_grd(5'd9, "R10 undefined global reads zero");
        op_grd(5'd1, "R10 alias global 2 untouched");
        op_gwr(5'd5, 8'h10);
        op_lwr(5'd0, 8'h55, 8'h55);
        op_lwr(5'd5, 8'h44, 8'h44);
        op_lrd(5'd0, "R10 local address 0");
        op_lrd(5'd1, "R10 local pair 1 untouched");
        xfer(8'hC3, r); xfer(8'hFF, r);
        xfer(8'h43, id); xfer(8'h00, id); xfer(8'h00, r);
        check("R10 space 10 id", {8'h0, id}, 16'h0081);
        check("R10 space 10 data", {8'h0, r}, 16'h0);
        op_grd(5'd0, "R10 R1 command after space 10");
        close_f();

        // randomised mix
        for (int it = 0; it < 10; it++) begin
            logic [4:0] ga, la, ca;
            ga = 5'($urandom_range(0, 9));
            la = 5'($urandom_range(0, 5));
            ca = 5'($urandom_range(0, 31));
            open_f();
            op_gwr(5'd5, {4'($urandom()), 4'h0});
            if (ga != 5'd5) op_gwr(ga, 8'($urandom()));
            op_grd(ga, "R2 R10 random global");
            op_lwr(la, 8'($urandom()), 8'($urandom()));
            op_lrd(la, "R3 R4 random local");
            close_f();
            open_f();
            fill_wbuf();
            op_cwr(ca, 16);
            op_gwr(5'd5, {4'($urandom()), 4'h0});
            op_crd(ca, "R6 R8 random coefficient");
            close_f();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule